// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block sits on the processor side of a shared system bus and hands the bus over to a direct-memory-access device. The device asks for the bus by pulling an active-low request line. The controller passes that line through a synchronizer. It then tells the processor's bus-cycle sequencer to stop issuing new cycles, and it lets any cycle already under way run to its end. Once the cycle has ended, the controller spends one clock with every processor driver switched off. Only after that clock does it assert the active-low grant.

When the device withdraws its request, the grant goes inactive on the next clock edge after the synchronized withdrawal is seen. The processor's drivers stay off for a parameterized guard time, counted in clock cycles, before the processor takes the address lines back. There are no tristate pads. The block produces separate output enables for the address, control and data drivers, and the pad ring uses them.

The asynchronous reset is released in step with the clock. During reset no grant is given and all drivers are off. After reset the drivers also wait out one guard interval before they come on.

Top module: `bus_hold_ctrl`

## Requirements
- R1: `hold_req_n` low means a hold is requested and `hold_ack_n` low means the hold is granted. The inactive level of both is 1.
- R2: A hold is granted only at a cycle boundary. While `cyc_active` is 1 the drivers stay enabled. They switch off at the first clock edge at which `cyc_active` is sampled 0 with the request still present.
- R3: `stall` is 1 from the cycle in which the synchronized request is first visible. It stays 1 for as long as the processor does not own the bus, and it is 0 in the idle owning state with no request.
- R4: The drivers are off for exactly one clock before `hold_ack_n` falls. With the bus idle and SYNC_STAGES=2, a request driven between edges turns the drivers off after the 3rd rising edge and pulls `hold_ack_n` low after the 4th. A pending cycle adds one edge per extra busy cycle.
- R5: After `hold_req_n` returns to 1, `hold_ack_n` returns to 1 after the 3rd rising edge (SYNC_STAGES=2).
- R6: After the grant is released, `addr_oe` and `ctrl_oe` stay 0 for GUARD_CYCLES further edges. They return to 1 after edge 3+GUARD_CYCLES, counted from the withdrawal, and `stall` falls on that same edge.
- R7: If the request is withdrawn while the controller is still waiting for a cycle to end, no grant is given. The drivers stay on, and `stall` falls after the 3rd edge.
- R8: While `rst_n` is 0, all enables are 0, `hold_ack_n` is 1, `stall` is 1, and a low `hold_req_n` is ignored. After `rst_n` rises, the enables come on after edge 2+GUARD_CYCLES.
- R9: `data_oe` is `data_drive` while the processor owns the bus, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_req_n | input | 1 | Active-low bus request from the DMA device (asynchronous) |
| cyc_active | input | 1 | Sequencer has a bus cycle in progress |
| data_drive | input | 1 | Sequencer wants the data bus driven (write cycle) |
| stall | output | 1 | Sequencer must not start a new bus cycle |
| hold_ack_n | output | 1 | Active-low bus grant to the DMA device |
| addr_oe | output | 1 | Enable for the processor address drivers |
| ctrl_oe | output | 1 | Enable for the processor control strobe drivers |
| data_oe | output | 1 | Enable for the processor data drivers |

## Verification
The hardest case to reach is a request that arrives while a bus cycle is still running and is then withdrawn before that cycle ends. It has to land inside the short window after synchronization and before the boundary. The stimulus reaches it by holding `cyc_active` high and releasing the request at several fixed edge offsets. A second sweep covers every combination of cycle-end delay and grant length, so that the float edge, the grant edge and the guard edge can each be predicted by arithmetic on those counts.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_END = 3'd1,
    ST_FLOAT    = 3'd2,
    ST_GRANTED  = 3'd3,
    ST_GUARD    = 3'd4
  } hold_state_e;

endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stage_in;
    if (i == 0) begin : g_first
      assign stage_in = d;
    end else begin : g_next
      assign stage_in = chain_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= RESET_VAL;
      else        chain_q[i] <= stage_in;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bhc_guard_timer.sv
module bhc_guard_timer #(
  parameter int CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] START = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                      cnt_d = START;
    else if (run && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= START;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R6: the remaining guard count never exceeds its load value
  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= START);

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bhc_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic cyc_active,
  input  logic data_drive,
  output logic stall,
  output logic hold_ack_n,
  output logic addr_oe,
  output logic ctrl_oe,
  output logic data_oe
);

  localparam int QW = $clog2(GUARD_CYCLES + 1);

  logic        rst_int_n;
  logic        req_n_s;
  logic        req;
  logic        guard_load;
  logic        guard_run;
  logic        guard_done;
  logic        own_bus;
  hold_state_e state_q, state_d;

  // reset: asserted at once, released on the clock
  bhc_sync #(.STAGES(2), .RESET_VAL(1'b0)) rst_sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_int_n)
  );

  // request synchronizer, held inactive during reset
  bhc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) req_sync_i (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (hold_req_n),
    .q    (req_n_s)
  );

  assign req = ~req_n_s;

  bhc_guard_timer #(.CYCLES(GUARD_CYCLES)) guard_i (
    .clk  (clk),
    .rst_n(rst_int_n),
    .load (guard_load),
    .run  (guard_run),
    .done (guard_done)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req) state_d = cyc_active ? ST_WAIT_END : ST_FLOAT;
      ST_WAIT_END: begin
        if (!req)             state_d = ST_IDLE;
        else if (!cyc_active) state_d = ST_FLOAT;
      end
      ST_FLOAT:    state_d = req ? ST_GRANTED : ST_GUARD;
      ST_GRANTED:  if (!req) state_d = ST_GUARD;
      ST_GUARD:    if (guard_done) state_d = ST_IDLE;
      default:     state_d = ST_GUARD;
    endcase
  end

  assign guard_load = (state_d == ST_GUARD) && (state_q != ST_GUARD);
  assign guard_run  = (state_q == ST_GUARD);

  // state register; reset lands in the guard interval with drivers off
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_GUARD;
    else            state_q <= state_d;
  end

  assign own_bus    = (state_q == ST_IDLE) || (state_q == ST_WAIT_END);
  assign addr_oe    = own_bus;
  assign ctrl_oe    = own_bus;
  assign data_oe    = own_bus & data_drive;
  assign hold_ack_n = (state_q != ST_GRANTED);
  assign stall      = (state_q != ST_IDLE) | req;

  // count of consecutive quiet cycles (no grant, no processor drive)
  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) quiet_q <= '0;
    else if (hold_ack_n && !addr_oe) begin
      if (quiet_q != QW'(GUARD_CYCLES)) quiet_q <= quiet_q + 1'b1;
    end else begin
      quiet_q <= '0;
    end
  end

  // R2: drivers switch off only after a cycle boundary was seen
  assert_float_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(addr_oe) |-> !$past(cyc_active));

  // R3: whenever the processor is off the bus the sequencer is stalled
  assert_stall_when_released_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !addr_oe |-> stall);

  // R4: the grant follows a cycle in which the drivers were already off
  assert_float_before_ack_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(hold_ack_n) |-> !$past(addr_oe));

  // R5: a withdrawn request drops the grant on the next edge
  assert_prompt_release_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!hold_ack_n && !req) |=> hold_ack_n);

  // R6: drivers return only after a full guard interval of quiet cycles
  assert_guard_gap_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(addr_oe) |-> (quiet_q == QW'(GUARD_CYCLES)));

endmodule

// File: tb/bus_hold_ctrl_tb_top.sv
module bus_hold_ctrl_tb_top;

  localparam int G = 3;

  logic clk = 1'b0;
  logic rst_n, hold_req_n, cyc_active, data_drive;
  logic stall, hold_ack_n, addr_oe, ctrl_oe, data_oe;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  bus_hold_ctrl #(.SYNC_STAGES(2), .GUARD_CYCLES(G)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_req_n(hold_req_n),
    .cyc_active(cyc_active),
    .data_drive(data_drive),
    .stall     (stall),
    .hold_ack_n(hold_ack_n),
    .addr_oe   (addr_oe),
    .ctrl_oe   (ctrl_oe),
    .data_oe   (data_oe)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input logic own, input logic ack_n,
                         input logic stl, input logic dd);
    chk({tag, " addr_oe"}, addr_oe, own);
    chk({tag, " ctrl_oe"}, ctrl_oe, own);
    chk({tag, " data_oe R9"}, data_oe, own & dd);
    chk({tag, " hold_ack_n"}, hold_ack_n, ack_n);
    chk({tag, " stall"}, stall, stl);
  endtask

  // request, optional pending cycle of w busy edges, grant held h edges
  task automatic run_grant(input int w, input int h);
    hold_req_n = 1'b0;
    cyc_active = (w > 0);
    data_drive = 1'b1;
    for (int e = 1; e <= 4 + w + h; e++) begin
      step();
      // R2 R4: float from edge 3+w, grant from edge 4+w; R3 stall from edge 2
      chk_all("R2/R4 grant", e < 3 + w, !(e >= 4 + w), e >= 2, 1'b1);
      if (w > 0 && e == 2 + w) cyc_active = 1'b0;
    end
    hold_req_n = 1'b1;
    for (int f = 1; f <= 4 + G; f++) begin
      step();
      // R5 ack back after edge 3; R6 drivers back after edge 3+G
      chk_all("R5/R6 release", f >= 3 + G, f >= 3, f < 3 + G, 1'b1);
    end
  endtask

  // R7: request withdrawn while a cycle is still pending
  task automatic run_abandon(input int e0);
    hold_req_n = 1'b0;
    cyc_active = 1'b1;
    data_drive = 1'b0;
    for (int e = 1; e <= e0; e++) begin
      step();
      chk_all("R7 pending", 1'b1, 1'b1, e >= 2, 1'b0);
    end
    hold_req_n = 1'b1;
    for (int f = 1; f <= 4; f++) begin
      step();
      chk_all("R7 abandon", 1'b1, 1'b1, f < 3, 1'b0);
    end
    cyc_active = 1'b0;
    step();
  endtask

  initial begin
    rst_n      = 1'b0;
    hold_req_n = 1'b0;
    cyc_active = 1'b0;
    data_drive = 1'b1;
    // R8 R1: during reset no grant, drivers off, request ignored
    for (int i = 0; i < 4; i++) begin
      step();
      chk_all("R8 in reset", 1'b0, 1'b1, 1'b1, 1'b1);
    end
    hold_req_n = 1'b1;
    step();
    rst_n = 1'b1;
    for (int e = 1; e <= 3 + G; e++) begin
      step();
      chk_all("R8 after reset", e >= 2 + G, 1'b1, e < 2 + G, 1'b1);
    end
    // R9: data enable follows data_drive while owning
    data_drive = 1'b0;
    step();
    chk("R9 data off", data_oe, 1'b0);
    data_drive = 1'b1;
    step();
    chk("R9 data on", data_oe, 1'b1);
    chk("R1 idle ack high", hold_ack_n, 1'b1);
    // sweep pending-cycle length and grant length
    for (int w = 0; w <= 4; w++)
      for (int h = 1; h <= 3; h++)
        run_grant(w, h);
    for (int e0 = 3; e0 <= 5; e0++)
      run_abandon(e0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule